// File: doc/BRIEF.md
# Two-Channel Streaming Read Engine

This block fetches runs of items from an external device on its own and places them in a small shared read FIFO for software to drain. It has two channels. Each channel holds an item size, a device-relative address and a remaining-item count. Writing a nonzero count starts a burst. The engine then requests one item at a time from the device, zero-extends each returned item to 32 bits and stores it. After each item, the channel's address steps forward by the item width.

When the FIFO is full, the engine stops requesting. It resumes as soon as an entry is popped, so no data is dropped. Writing a zero count cancels a burst. Addresses persist between bursts, so a channel can be restarted with only a new count. Software can alternate between the two channels to stream without gaps. Channel 0 has priority for each new request. A request already shown to the device stays in place until the device accepts it.

Register access uses a 3-bit index. Bit 2 selects the channel. Bits 1:0 select the field: 0 is item size, 1 is address, 2 is count, and 3 is the FIFO level (the same for either channel).

Top module: `rd_stream_engine`

## Requirements
- R1: After reset, every size, address and count reads 0, the FIFO level is 0 and `ext_req_o` is low.
- R2: Writing a nonzero value to a channel's count field (low 12 bits) starts a burst. Each cycle with both `ext_req_o` and `ext_ack_i` high stores one FIFO entry from `ext_rdata_i` and decrements that channel's count. Entries leave the FIFO in the order the device delivered them.
- R3: Size encodings are 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. `ext_size_o` carries the encoding of the channel being served. Each accepted item advances that channel's address by 1, 2 or 4 respectively.
- R4: A stored item keeps bits 7:0 for size 0, bits 15:0 for size 1 and all 32 bits for size 2. All other bits are zero.
- R5: The FIFO holds 8 entries. `ext_req_o` stays low while 8 entries are held, and requesting resumes after a pop. No item of the burst is lost.
- R6: Writing 0 to a channel's count cancels its burst. From the next cycle that channel makes no request, its count reads 0, and its address points just past the last accepted item.
- R7: Reading a channel's count returns the number of items of the burst still outstanding.
- R8: A new burst on a channel without an address write continues from the address where the previous burst ended.
- R9: When both channels have pending items and no request is outstanding, channel 0 is served. A request presented to the device keeps its address and size until accepted, even if the other channel starts meanwhile.
- R10: Field 3 and `fifo_level_o` report the FIFO occupancy. `pop_data_o` shows the oldest entry. `pop_i` while the FIFO is empty has no effect.
- R11: The address field holds 29 bits. Upper write bits are dropped, and the address wraps from 0x1FFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: bit 2 channel, bits 1:0 field |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from `reg_addr_i` |
| ext_req_o | output | 1 | Item request to the external device |
| ext_addr_o | output | 29 | Device-relative address of the requested item |
| ext_size_o | output | 2 | Size encoding of the requested item |
| ext_ack_i | input | 1 | Device delivers the requested item this cycle |
| ext_rdata_i | input | 32 | Item data from the device |
| pop_i | input | 1 | Remove the oldest FIFO entry |
| pop_data_o | output | 32 | Oldest FIFO entry |
| fifo_level_o | output | 4 | Number of FIFO entries held |

## Verification
- A register write takes effect at the clock edge that samples it. `ext_req_o`, `ext_addr_o` and `ext_size_o` follow combinationally from the updated state, so a started burst is visible in the same half cycle after that edge.
- An accepted item raises the level and lowers the count at the edge where both `ext_req_o` and `ext_ack_i` are high. A pop shows the next entry right after its edge.
- The bench drives all inputs and samples all outputs on the falling edge, so each check sees the state after exactly one rising edge.
- A device model computes each item from its address. The bench predicts the whole item sequence, including the ordering between the two channels, before it enables acknowledgement. A monitor then compares every popped entry against that prediction.

// File: rtl/rse_pkg.sv
package rse_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } item_size_e;

  typedef enum logic [1:0] {
    FLD_SIZE  = 2'd0,
    FLD_ADDR  = 2'd1,
    FLD_COUNT = 2'd2,
    FLD_LEVEL = 2'd3
  } reg_field_e;

  function automatic logic [2:0] size_step(logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(logic [1:0] sz, logic [31:0] d);
    case (sz)
      SZ_BYTE: return {24'd0, d[7:0]};
      SZ_HALF: return {16'd0, d[15:0]};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/rse_channel.sv
module rse_channel
  import rse_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_size_i,
  input  logic              wr_addr_i,
  input  logic              wr_cnt_i,
  input  logic [1:0]        size_d_i,
  input  logic [ADDR_W-1:0] addr_d_i,
  input  logic [CNT_W-1:0]  cnt_d_i,
  input  logic              take_i,
  output logic [1:0]        size_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              active_o
);

  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= SZ_BYTE;
    end else if (wr_size_i) begin
      size_q <= size_d_i;
    end
  end

  // Software write wins over the advance of an item taken in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (wr_addr_i) begin
      addr_q <= addr_d_i;
    end else if (take_i) begin
      addr_q <= addr_q + ADDR_W'(size_step(size_q));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_cnt_i) begin
      cnt_q <= cnt_d_i;
    end else if (take_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign size_o   = size_q;
  assign addr_o   = addr_q;
  assign cnt_o    = cnt_q;
  assign active_o = (cnt_q != '0);

  a_r2_take_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> cnt_q != '0);

  a_r7_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !wr_cnt_i |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  a_r6_count_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i && !wr_cnt_i |=> $stable(cnt_q));

endmodule

// File: rtl/rse_arbiter.sv
module rse_arbiter #(
  parameter int CH_N = 2,
  localparam int SEL_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CH_N-1:0]  active_i,
  input  logic             space_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [CH_N-1:0]  take_o
);

  logic             hold_q;
  logic [SEL_W-1:0] owner_q;
  logic [SEL_W-1:0] fresh;

  // Lowest index with pending items wins.
  always_comb begin
    fresh = '0;
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (active_i[i]) fresh = SEL_W'(i);
    end
  end

  // An unanswered request keeps its channel unless that channel was cancelled.
  assign sel_o = (hold_q && active_i[owner_q]) ? owner_q : fresh;
  assign req_o = (|active_i) && space_i;

  for (genvar g = 0; g < CH_N; g++) begin : g_take
    assign take_o[g] = req_o && ack_i && (sel_o == SEL_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= 1'b0;
      owner_q <= '0;
    end else begin
      hold_q  <= req_o && !ack_i;
      owner_q <= sel_o;
    end
  end

  a_r2_take_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take_o));

  a_r9_take_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o & ~active_i) == '0);

endmodule

// File: rtl/rse_fifo.sv
module rse_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] level_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_o  = (level_q == LVL_W'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && (level_q != '0);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wptr_q <= ptr_next(wptr_q);
      if (pop_ok)  rptr_q <= ptr_next(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + LVL_W'(1);
        2'b01:   level_q <= level_q - LVL_W'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  assign data_o  = mem_q[rptr_q];
  assign level_o = level_q;

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  a_r10_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && level_q == '0 && !push_i |=> level_q == '0);

endmodule

// File: rtl/rd_stream_engine.sv
module rd_stream_engine
  import rse_pkg::*;
#(
  parameter int ADDR_W     = 29,
  parameter int CNT_W      = 12,
  parameter int FIFO_DEPTH = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              ext_req_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [1:0]        ext_size_o,
  input  logic              ext_ack_i,
  input  logic [31:0]       ext_rdata_i,
  input  logic              pop_i,
  output logic [31:0]       pop_data_o,
  output logic [LVL_W-1:0]  fifo_level_o
);

  localparam int CH_N  = 2;
  localparam int SEL_W = 1;

  logic [1:0]        ch_size   [CH_N];
  logic [ADDR_W-1:0] ch_addr   [CH_N];
  logic [CNT_W-1:0]  ch_cnt    [CH_N];
  logic [CH_N-1:0]   ch_active;
  logic [CH_N-1:0]   ch_take;
  logic [SEL_W-1:0]  sel;
  logic              fifo_full;
  logic [LVL_W-1:0]  level;
  logic [1:0]        field;
  logic              unused_wdata;

  assign field        = reg_addr_i[1:0];
  assign unused_wdata = ^reg_wdata_i[31:ADDR_W];

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic hit;
    assign hit = reg_we_i && (reg_addr_i[2] == 1'(g));

    rse_channel #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W)
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_size_i(hit && field == FLD_SIZE),
      .wr_addr_i(hit && field == FLD_ADDR),
      .wr_cnt_i (hit && field == FLD_COUNT),
      .size_d_i (reg_wdata_i[1:0]),
      .addr_d_i (reg_wdata_i[ADDR_W-1:0]),
      .cnt_d_i  (reg_wdata_i[CNT_W-1:0]),
      .take_i   (ch_take[g]),
      .size_o   (ch_size[g]),
      .addr_o   (ch_addr[g]),
      .cnt_o    (ch_cnt[g]),
      .active_o (ch_active[g])
    );
  end

  rse_arbiter #(
    .CH_N(CH_N)
  ) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(ch_active),
    .space_i (!fifo_full),
    .ack_i   (ext_ack_i),
    .req_o   (ext_req_o),
    .sel_o   (sel),
    .take_o  (ch_take)
  );

  assign ext_addr_o = ch_addr[sel];
  assign ext_size_o = ch_size[sel];

  rse_fifo #(
    .DEPTH(FIFO_DEPTH),
    .WIDTH(32)
  ) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (ext_req_o && ext_ack_i),
    .data_i (size_mask(ext_size_o, ext_rdata_i)),
    .pop_i  (pop_i),
    .data_o (pop_data_o),
    .level_o(level),
    .full_o (fifo_full)
  );

  assign fifo_level_o = level;

  always_comb begin
    case (field)
      FLD_SIZE:  reg_rdata_o = 32'(ch_size[reg_addr_i[2]]);
      FLD_ADDR:  reg_rdata_o = 32'(ch_addr[reg_addr_i[2]]);
      FLD_COUNT: reg_rdata_o = 32'(ch_cnt[reg_addr_i[2]]);
      default:   reg_rdata_o = 32'(level);
    endcase
  end

  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o && !ext_ack_i && !reg_we_i
      |=> ext_req_o && $stable(ext_addr_o) && $stable(ext_size_o));

  a_r5_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> fifo_level_o < LVL_W'(FIFO_DEPTH));

  a_r6_cancel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 3'd2 && reg_wdata_i[CNT_W-1:0] == '0 && ch_cnt[1] == '0
      |=> !ext_req_o);

endmodule

// File: tb/rd_stream_engine_test.sv
module rd_stream_engine_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        ext_req_o;
  logic [28:0] ext_addr_o;
  logic [1:0]  ext_size_o;
  logic        ext_ack_i = 1'b0;
  logic [31:0] ext_rdata_i;
  logic        pop_i = 1'b0;
  logic [31:0] pop_data_o;
  logic [3:0]  fifo_level_o;

  int checks = 0;
  int errors = 0;
  logic pop_en = 1'b0;
  logic force_pop = 1'b0;
  logic [31:0] exp_q[$];
  logic [28:0] m_addr [2];
  logic [1:0]  m_size [2];

  always #5 clk = ~clk;

  rd_stream_engine uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .ext_req_o(ext_req_o), .ext_addr_o(ext_addr_o), .ext_size_o(ext_size_o),
    .ext_ack_i(ext_ack_i), .ext_rdata_i(ext_rdata_i),
    .pop_i(pop_i), .pop_data_o(pop_data_o), .fifo_level_o(fifo_level_o)
  );

  function automatic logic [31:0] dev_word(logic [28:0] a);
    return ({3'b0, a} * 32'h9E37_79B1) ^ 32'hA5A5_5A5A;
  endfunction

  // Device model: data is a function of the requested address.
  assign ext_rdata_i = dev_word(ext_addr_o);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic set_ch(input int ch, input logic [1:0] sz, input logic [31:0] a);
    wr({ch[0], 2'd0}, {30'd0, sz});
    wr({ch[0], 2'd1}, a);
    m_size[ch] = sz;
    m_addr[ch] = a[28:0];
  endtask

  task automatic push_item(input int ch);
    logic [31:0] d;
    d = dev_word(m_addr[ch]);
    case (m_size[ch])
      2'd0: d = d & 32'hFF;
      2'd1: d = d & 32'hFFFF;
      default: ;
    endcase
    exp_q.push_back(d);
    m_addr[ch] = m_addr[ch] + ((m_size[ch] == 2'd0) ? 29'd1 : (m_size[ch] == 2'd1) ? 29'd2 : 29'd4);
  endtask

  task automatic burst(input int ch, input int n);
    for (int i = 0; i < n; i++) push_item(ch);
    wr({ch[0], 2'd2}, n);
  endtask

  task automatic drain(input string tag);
    int k = 0;
    while ((exp_q.size() != 0 || fifo_level_o != 0 || ext_req_o) && k < 500) begin
      @(negedge clk);
      k++;
    end
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // Monitor: pops and compares against the predicted sequence.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_ni) begin
        pop_i = 1'b0;
      end else begin
        if (pop_en && fifo_level_o != 0) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected item", pop_data_o, 32'h0);
          end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(pop_data_o == e, "R2/R4 item data", pop_data_o, e);
          end
        end
        pop_i = force_pop || (pop_en && fifo_level_o != 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_addr[0] = '0; m_addr[1] = '0; m_size[0] = '0; m_size[1] = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check(v == 0, "R1 register reset", v, 0);
    end
    check(fifo_level_o == 0, "R1 level reset", 32'(fifo_level_o), 0);
    check(ext_req_o == 1'b0, "R1 no request", 32'(ext_req_o), 0);

    // R2 R3 R7 word burst on channel 0
    ext_ack_i = 1'b1; pop_en = 1'b1;
    set_ch(0, 2'd2, 32'h100);
    burst(0, 5);
    drain("R2 word burst");
    rd(3'd2, v); check(v == 0, "R7 count done", v, 0);
    rd(3'd1, v); check(v == 32'h114, "R3 word step", v, 32'h114);

    // R8 continue from previous address
    burst(0, 3);
    drain("R8 continued burst");
    rd(3'd1, v); check(v == 32'h120, "R8 address kept", v, 32'h120);

    // R11 29-bit address and wrap, 16-bit items
    set_ch(1, 2'd1, 32'hFFFF_FFFF);
    rd(3'd5, v); check(v == 32'h1FFF_FFFF, "R11 address width", v, 32'h1FFF_FFFF);
    burst(1, 2);
    drain("R11 wrap burst");
    rd(3'd5, v); check(v == 32'h3, "R11 address wrap", v, 32'h3);

    // R4 R3 byte items
    set_ch(1, 2'd0, 32'h40);
    burst(1, 4);
    drain("R4 byte burst");
    rd(3'd5, v); check(v == 32'h44, "R3 byte step", v, 32'h44);

    // R5 backpressure
    pop_en = 1'b0;
    burst(0, 12);
    repeat (20) @(negedge clk);
    check(fifo_level_o == 8, "R5 fifo full", 32'(fifo_level_o), 8);
    check(ext_req_o == 1'b0, "R5 request stalled", 32'(ext_req_o), 0);
    rd(3'd2, v); check(v == 4, "R7 count while stalled", v, 4);
    pop_en = 1'b1;
    drain("R5 resumed burst");

    // R6 cancel after three items
    ext_ack_i = 1'b0; pop_en = 1'b0;
    for (int i = 0; i < 3; i++) push_item(0);
    wr(3'd2, 32'd10);
    ext_ack_i = 1'b1;
    repeat (3) @(negedge clk);
    ext_ack_i = 1'b0;
    rd(3'd2, v); check(v == 7, "R7 count after three", v, 7);
    wr(3'd2, 32'd0);
    check(ext_req_o == 1'b0, "R6 request stops", 32'(ext_req_o), 0);
    rd(3'd2, v); check(v == 0, "R6 count cleared", v, 0);
    rd(3'd1, v); check(v == 32'(m_addr[0]), "R6 address after cancel", v, 32'(m_addr[0]));
    check(fifo_level_o == 3, "R6 items kept", 32'(fifo_level_o), 3);
    pop_en = 1'b1;
    drain("R6 cancelled burst");

    // R9 held request and channel 0 priority
    pop_en = 1'b0;
    set_ch(1, 2'd2, 32'h800);
    push_item(1);
    push_item(0); push_item(0);
    push_item(1); push_item(1);
    wr(3'd6, 32'd3);
    @(negedge clk);
    check(ext_req_o && ext_addr_o == 29'h800, "R9 channel 1 request", 32'(ext_addr_o), 32'h800);
    wr(3'd2, 32'd2);
    check(ext_addr_o == 29'h800, "R9 request held", 32'(ext_addr_o), 32'h800);
    check(ext_size_o == 2'd2, "R3 size shown", 32'(ext_size_o), 2);
    ext_ack_i = 1'b1; pop_en = 1'b1;
    drain("R9 interleaved order");

    // R10 pop on empty, level readback and show-ahead
    force_pop = 1'b1;
    @(negedge clk);
    force_pop = 1'b0;
    @(negedge clk);
    check(fifo_level_o == 0, "R10 empty pop ignored", 32'(fifo_level_o), 0);
    pop_en = 1'b0;
    burst(0, 1);
    repeat (3) @(negedge clk);
    rd(3'd3, v); check(v == 1, "R10 level field", v, 1);
    rd(3'd7, v); check(v == 1, "R10 level field channel 1", v, 1);
    check(pop_data_o == exp_q[0], "R10 oldest shown", pop_data_o, exp_q[0]);
    pop_en = 1'b1;
    drain("R10 final drain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule